// File: doc/BRIEF.md
# Frame Segment Sequencer

This block steers one processing channel through a single frame. A start pulse latches the frame configuration: total length, header count, payload count, countdown threshold, frame identifier and the identifier-post enable. If that enable is set, the block first places the 32-bit identifier on its output stream. It then passes input bytes through to the output stream and tags each byte. A byte is tagged for processing when it lies in the payload window. Bytes in the leading header and in the trailing section are tagged as bypass. The downstream cipher or hash engine uses the tag to decide what to transform.

Both streams use valid/ready. A transfer takes place on a rising clock edge where valid and ready are both high. In the data phase the block adds no storage. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`, so back-pressure from the consumer reaches the producer in the same cycle. While the identifier word is pending, `in_ready` is low and the identifier is held on the output until the consumer takes it.

A countdown of the bytes still to come is visible on `left_count`. A one-cycle `thresh_hit` pulse warns early that the frame is close to completion. A one-cycle `done` pulse marks the end of the frame. A `stop` input abandons the frame at any time.

Top module: `frame_segmenter`

## Requirements
- R1: When the identifier enable is set at start, the first output transfer is the full 32-bit frame identifier with `out_is_id`=1 and `out_proc`=0. No input byte is accepted (`in_ready`=0) until that word has been taken.
- R2: In the data phase, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. The accepted byte appears on `out_data[7:0]`, and the upper bits of `out_data` are zero.
- R3: Bytes at positions 0 to header-1 of the frame (position counted from 0 in arrival order) carry `out_proc`=0.
- R4: Bytes at positions header to header+payload-1 carry `out_proc`=1. When header plus payload exceeds the frame length, the window is cut at the frame end.
- R5: Bytes after the payload window carry `out_proc`=0. Exactly frame-length bytes are accepted, after which `in_ready` stays low.
- R6: `left_count` is loaded with the frame length at start and drops by one on each accepted byte.
- R7: `thresh_hit` is high for exactly one cycle. That cycle follows the accepted byte that brings `left_count` from above the threshold down to equal it. Loading the count never raises it.
- R8: While `chan_en` is low, a start pulse is ignored: `busy`, `out_valid` and `in_ready` stay low.
- R9: `done` is high for one cycle. That cycle follows the last accepted byte, or follows the start or identifier transfer when the frame length is zero. `busy` is low during and after that cycle.
- R10: When `stop` is high, the cycle after it has `busy`, `out_valid`, `in_ready` and `done` low, whatever state the block was in.
- R11: The configuration inputs are sampled only on the start cycle. Changing them during a frame has no effect on tagging, counting or the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; start is ignored when low |
| id_post_en | input | 1 | Emit identifier word before data |
| start | input | 1 | Start pulse (taken only when idle) |
| stop | input | 1 | Abandon the frame, return to idle |
| frame_id | input | ID_W | Frame identifier word |
| frame_len | input | LEN_W | Total frame length in bytes |
| hdr_len | input | LEN_W | Leading bypass byte count |
| pay_len | input | LEN_W | Processed byte count |
| thresh_len | input | LEN_W | Countdown threshold for the early event |
| in_valid | input | 1 | Input byte valid |
| in_data | input | BYTE_W | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | ID_W | Identifier word or zero-extended byte |
| out_is_id | output | 1 | Output word is the frame identifier |
| out_proc | output | 1 | Output byte is to be processed |
| out_ready | input | 1 | Consumer ready |
| left_count | output | LEN_W | Bytes still to be accepted |
| thresh_hit | output | 1 | Early-completion pulse |
| busy | output | 1 | Identifier or data phase active |
| done | output | 1 | Frame complete pulse |

## Verification
The sweep covers every combination of frame length 0 to 6, header 0 to 3, payload 0 to 4, identifier on or off and three flow patterns. This walks the tag boundary through every position, including empty and fully truncated payload windows. The three flow patterns are a free-running stream, a gappy producer and a stalling consumer. Comparing them separates correct pass-through of back-pressure from a design that only works at full rate. Thresholds derived from the configuration fall both inside and outside the frame, so a missed pulse and a spurious one at load time are both visible. The configuration inputs are scrambled after each start, and separate sequences cover a disabled start and stops during the identifier and data phases.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ID   = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } fsq_state_e;

endpackage

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       stop,
  input  logic       id_en,
  input  logic       len_zero_in,
  input  logic       len_zero_q,
  input  logic       id_taken,
  input  logic       last_byte,
  output fsq_state_e state
);

  fsq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (go) begin
          if (id_en)            nxt = ST_ID;
          else if (len_zero_in) nxt = ST_FIN;
          else                  nxt = ST_DATA;
        end
      end
      ST_ID: begin
        if (id_taken) nxt = len_zero_q ? ST_FIN : ST_DATA;
      end
      ST_DATA: begin
        if (last_byte) nxt = ST_FIN;
      end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (stop) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/fsq_countdown.sv
module fsq_countdown #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic [LEN_W-1:0] thr_in,
  input  logic             dec,
  input  logic             clear,
  output logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] pos,
  output logic             hit
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] thr_q;
  logic [LEN_W-1:0] remain_dec;

  assign remain_dec = remain - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      pos    <= '0;
      thr_q  <= '0;
      hit    <= 1'b0;
    end else if (clear) begin
      hit <= 1'b0;
    end else if (load) begin
      remain <= len_in;
      pos    <= '0;
      thr_q  <= thr_in;
      hit    <= 1'b0;
    end else if (dec) begin
      remain <= remain_dec;
      pos    <= pos + ONE;
      hit    <= (remain_dec == thr_q);
    end else begin
      hit <= 1'b0;
    end
  end

endmodule

// File: rtl/fsq_tagger.sv
module fsq_tagger #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] pos,
  input  logic [LEN_W-1:0] hdr,
  input  logic [LEN_W-1:0] pay,
  output logic             in_window
);

  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] pos_x;
  logic [SUM_W-1:0] lo_x;
  logic [SUM_W-1:0] hi_x;

  assign pos_x     = {1'b0, pos};
  assign lo_x      = {1'b0, hdr};
  assign hi_x      = {1'b0, hdr} + {1'b0, pay};
  assign in_window = (pos_x >= lo_x) && (pos_x < hi_x);

endmodule

// File: rtl/frame_segmenter.sv
module frame_segmenter
  import fsq_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ID_W   = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              id_post_en,
  input  logic              start,
  input  logic              stop,
  input  logic [ID_W-1:0]   frame_id,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic [LEN_W-1:0]  thresh_len,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_data,
  output logic              out_is_id,
  output logic              out_proc,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  left_count,
  output logic              thresh_hit,
  output logic              busy,
  output logic              done
);

  localparam int PAD_W = ID_W - BYTE_W;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  fsq_state_e       state;
  logic             go;
  logic             accept;
  logic             last_byte;
  logic             id_taken;
  logic             in_window;
  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] hdr_q;
  logic [LEN_W-1:0] pay_q;
  logic [ID_W-1:0]  id_q;

  assign go        = start && chan_en && (state == ST_IDLE) && !stop;
  assign accept    = (state == ST_DATA) && in_valid && out_ready;
  assign last_byte = accept && (left_count == ONE);
  assign id_taken  = (state == ST_ID) && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      pay_q <= '0;
      id_q  <= '0;
    end else if (go) begin
      hdr_q <= hdr_len;
      pay_q <= pay_len;
      id_q  <= frame_id;
    end
  end

  fsq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .stop        (stop),
    .id_en       (id_post_en),
    .len_zero_in (frame_len == '0),
    .len_zero_q  (left_count == '0),
    .id_taken    (id_taken),
    .last_byte   (last_byte),
    .state       (state)
  );

  fsq_countdown #(.LEN_W(LEN_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (go),
    .len_in (frame_len),
    .thr_in (thresh_len),
    .dec    (accept),
    .clear  (stop),
    .remain (left_count),
    .pos    (pos),
    .hit    (thresh_hit)
  );

  fsq_tagger #(.LEN_W(LEN_W)) u_tag (
    .pos       (pos),
    .hdr       (hdr_q),
    .pay       (pay_q),
    .in_window (in_window)
  );

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_is_id = 1'b0;
    out_proc  = 1'b0;
    in_ready  = 1'b0;
    unique case (state)
      ST_ID: begin
        out_valid = 1'b1;
        out_data  = id_q;
        out_is_id = 1'b1;
      end
      ST_DATA: begin
        out_valid = in_valid;
        out_data  = {{PAD_W{1'b0}}, in_data};
        out_proc  = in_window;
        in_ready  = out_ready;
      end
      default: ;
    endcase
  end

  assign busy = (state == ST_ID) || (state == ST_DATA);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/frame_segmenter_chk.sv
module frame_segmenter_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             stop,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_is_id,
  input logic             out_proc,
  input logic             out_ready,
  input logic [LEN_W-1:0] left_count,
  input logic             thresh_hit,
  input logic             busy,
  input logic             done
);

  // R1: identifier word blocks input and is never tagged
  p_id_blocks_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_id) |-> (!in_ready && !out_proc));

  // R2: ready passes through from the consumer
  p_ready_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_ready && busy));

  // R2: valid mirrors the producer in the data phase
  p_valid_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !out_is_id) |-> (out_valid == in_valid));

  // R6: each accepted byte decrements the countdown
  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !stop) |=> (left_count == $past(left_count) - 1'b1));

  // R7: threshold pulse only follows an accepted byte and lasts one cycle
  p_thresh_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_hit |-> $past(in_valid && in_ready));

  p_thresh_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_hit |=> !thresh_hit);

  // R8: a disabled channel stays idle
  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !chan_en) |=> !busy);

  // R9: done is a single pulse with the block idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !in_ready));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R10: stop returns the block to idle
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !out_valid && !done && !in_ready));

endmodule

bind frame_segmenter frame_segmenter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_en    (chan_en),
  .stop       (stop),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_is_id  (out_is_id),
  .out_proc   (out_proc),
  .out_ready  (out_ready),
  .left_count (left_count),
  .thresh_hit (thresh_hit),
  .busy       (busy),
  .done       (done)
);

// File: tb/test_frame_segmenter.sv
`timescale 1ns/1ps
module test_frame_segmenter;

  localparam int LEN_W  = 16;
  localparam int ID_W   = 32;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              chan_en = 1'b1;
  logic              id_post_en = 1'b0;
  logic              start = 1'b0;
  logic              stop = 1'b0;
  logic [ID_W-1:0]   frame_id = '0;
  logic [LEN_W-1:0]  frame_len = '0;
  logic [LEN_W-1:0]  hdr_len = '0;
  logic [LEN_W-1:0]  pay_len = '0;
  logic [LEN_W-1:0]  thresh_len = '0;
  logic              in_valid = 1'b0;
  logic [BYTE_W-1:0] in_data = '0;
  logic              in_ready;
  logic              out_valid;
  logic [ID_W-1:0]   out_data;
  logic              out_is_id;
  logic              out_proc;
  logic              out_ready = 1'b0;
  logic [LEN_W-1:0]  left_count;
  logic              thresh_hit;
  logic              busy;
  logic              done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  frame_segmenter #(.LEN_W(LEN_W), .ID_W(ID_W), .BYTE_W(BYTE_W)) i_frame_segmenter (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .id_post_en(id_post_en),
    .start(start), .stop(stop), .frame_id(frame_id), .frame_len(frame_len),
    .hdr_len(hdr_len), .pay_len(pay_len), .thresh_len(thresh_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_is_id(out_is_id),
    .out_proc(out_proc), .out_ready(out_ready), .left_count(left_count),
    .thresh_hit(thresh_hit), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] byte_of(input int k, input int len);
    return 8'((k * 37 + len * 5 + 3) & 255);
  endfunction

  task automatic run_frame(input int len, input int hdr, input int pay, input int thr,
                           input bit iden, input int bp);
    int  k = 0;
    bit  idp = iden;
    bit  exp_hit = 1'b0;
    bit  exp_done = 1'b0;
    bit  exp_proc;
    logic [ID_W-1:0] idw;
    idw = 32'hA500_0000 | ID_W'(len << 12) | ID_W'(hdr << 8) | ID_W'(pay << 4) | ID_W'(thr);
    @(negedge clk);
    frame_len = LEN_W'(len); hdr_len = LEN_W'(hdr); pay_len = LEN_W'(pay);
    thresh_len = LEN_W'(thr); frame_id = idw; id_post_en = iden;
    start = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble configuration after the start cycle
    frame_len = ~frame_len; hdr_len = hdr_len ^ 16'h5; pay_len = pay_len ^ 16'h3;
    thresh_len = thresh_len + 16'd1; frame_id = ~frame_id; id_post_en = ~id_post_en;
    chk(left_count == LEN_W'(len), "R6 load", left_count, len);
    if (len == 0 && !iden) exp_done = 1'b1;
    forever begin
      in_valid  = (bp == 1) ? ((cyc % 3) != 0) : 1'b1;
      out_ready = (bp == 2) ? ((cyc % 2) == 0) : 1'b1;
      in_data   = byte_of(k, len);
      #1;
      chk(thresh_hit == exp_hit, "R7 thresh_hit", thresh_hit, exp_hit);
      chk(done == exp_done, "R9 done", done, exp_done);
      if (exp_done) begin
        chk(!busy && !in_ready && !out_valid, "R9 idle at done", {busy, in_ready, out_valid}, 0);
        chk(k == len, "R5 byte total", k, len);
        cyc++;
        return;
      end
      exp_hit = 1'b0;
      if (idp) begin
        chk(out_valid && out_is_id && !out_proc, "R1 id flags", {out_valid, out_is_id, out_proc}, 3'b110);
        chk(out_data == idw, "R1 R11 id word", out_data, idw);
        chk(!in_ready, "R1 input held", in_ready, 0);
        if (out_ready) begin
          idp = 1'b0;
          if (len == 0) exp_done = 1'b1;
        end
      end else begin
        chk(out_valid == in_valid && in_ready == out_ready && busy && !out_is_id,
            "R2 handshake", {out_valid, in_ready, busy, out_is_id}, {in_valid, out_ready, 2'b10});
        if (in_valid && out_ready) begin
          exp_proc = (k >= hdr) && (k < hdr + pay) && (k < len);
          if (k < hdr)            chk(out_proc == 1'b0, "R3 header tag", out_proc, 0);
          else if (k < hdr + pay) chk(out_proc == 1'b1, "R4 payload tag", out_proc, 1);
          else                    chk(out_proc == 1'b0, "R5 trailer tag", out_proc, 0);
          chk(out_proc == exp_proc, "R11 tag uses latched config", out_proc, exp_proc);
          chk(out_data == ID_W'(byte_of(k, len)), "R2 data", out_data, byte_of(k, len));
          chk(left_count == LEN_W'(len - k), "R6 countdown", left_count, len - k);
          k++;
          if (len - k == thr) exp_hit = 1'b1;
          if (k == len) exp_done = 1'b1;
        end
      end
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !out_valid && !in_ready && !done && !thresh_hit && left_count == 0,
        "R9 reset state", {busy, out_valid, in_ready, done, thresh_hit}, 0);
    rst_n = 1'b1;

    for (int bp = 0; bp < 3; bp++)
      for (int len = 0; len <= 6; len++)
        for (int hdr = 0; hdr <= 3; hdr++)
          for (int pay = 0; pay <= 4; pay++)
            for (int ie = 0; ie < 2; ie++)
              run_frame(len, hdr, pay, (len + hdr + pay) % 7, ie[0], bp);

    // R8: start with channel disabled
    @(negedge clk);
    chan_en = 1'b0; start = 1'b1; frame_len = 16'd4; id_post_en = 1'b1;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(!busy && !out_valid && !in_ready && !done, "R8 disabled start", {busy, out_valid, in_ready, done}, 0);
    chan_en = 1'b1;

    // R10: stop during the data phase
    @(negedge clk);
    id_post_en = 1'b0; frame_len = 16'd6; hdr_len = 16'd1; pay_len = 16'd2; thresh_len = 16'd4;
    start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0; in_valid = 1'b1;
    #1;
    chk(!busy && !out_valid && !in_ready && !done, "R10 stop in data", {busy, out_valid, in_ready, done}, 0);
    chk(!thresh_hit, "R10 no threshold after stop", thresh_hit, 0);
    @(negedge clk);
    #1;
    chk(!done && !busy, "R10 no done after stop", {done, busy}, 0);

    // R10: stop while the identifier is pending
    @(negedge clk);
    id_post_en = 1'b1; start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(out_valid && out_is_id, "R1 id pending", {out_valid, out_is_id}, 2'b11);
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0; out_ready = 1'b1;
    #1;
    chk(!busy && !out_valid && !done, "R10 stop in id", {busy, out_valid, done}, 0);

    // block still works after stops
    run_frame(5, 1, 2, 1, 1'b1, 0);
    run_frame(3, 0, 9, 0, 1'b0, 2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule